// File: doc/BRIEF.md
# Programmable-length serial bit counter

This block keeps track of how many bit slots are left in one serial frame for a shift engine that has two modes. In the I2C-style mode every frame ends with an acknowledge slot. In the plain clocked synchronous mode there is no such slot. Software programs a 3-bit length field. The shift engine marks the start of each frame with a pulse and sends one strobe per bit. The block counts the frame down and reports the bits still to go through a readback port. It raises a one-cycle pulse when the last slot has been consumed, and then the field reads zero again.

The field uses a wrap-around encoding: the all-zero value stands for a full frame. In I2C mode each value also covers the acknowledge slot, so one field value gives a different frame length in each mode. The block also combines the transmit-empty flag with a software enable to form a maskable transmit interrupt request.

Top module: `serial_bit_tally`

## Requirements
- R1: In I2C mode (`mode_i2c`=1 at frame start), a field of 000 gives a frame of 9 strobes. A field value k from 1 to 7 gives k+1 strobes.
- R2: In synchronous mode (`mode_i2c`=0 at frame start), a field of 000 gives a frame of 8 strobes. A field value k from 1 to 7 gives k strobes.
- R3: While no frame is active, `cnt_rd` shows the stored field. While a frame is active, `cnt_rd` shows the remaining slot count n, taken modulo 8. In I2C mode it shows n-1 and in synchronous mode it shows n. The value changes only on a bit strobe.
- R4: The strobe that consumes the last slot does three things in the next cycle: `frame_done` goes high for exactly one cycle, `frame_busy` drops, and `cnt_rd` reads 000.
- R5: In I2C mode, a field write is ignored while a frame is active or while `frame_start` is high. A non-zero value is accepted only when `scl_low`=1. The value 000 is accepted whatever the level of `scl_low`.
- R6: In synchronous mode, field writes are ignored.
- R7: Bit strobes that arrive while no frame is active are ignored. A `frame_start` during an active frame is ignored. The mode is sampled once, at frame start.
- R8: `txi_req` is 1 exactly when `tx_empty` is 1 and the interrupt enable bit is 1. The enable bit is written through `irq_en_we`/`irq_en_wd`.
- R9: After reset, the field is 000, no frame is active, `frame_done` is 0 and the interrupt enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i2c | input | 1 | 1 selects I2C mode with an acknowledge slot, 0 selects plain synchronous mode |
| scl_low | input | 1 | 1 while the serial clock line is low |
| cnt_wr_en | input | 1 | Field write strobe |
| cnt_wr_data | input | FIELD_W | Field write value |
| frame_start | input | 1 | Start-of-frame pulse from the shift engine |
| bit_strobe | input | 1 | One pulse per transferred bit slot |
| tx_empty | input | 1 | Transmit-data-empty flag |
| irq_en_we | input | 1 | Interrupt enable write strobe |
| irq_en_wd | input | 1 | Interrupt enable write value |
| cnt_rd | output | FIELD_W | Stored field when idle, re-encoded remaining count when active |
| frame_busy | output | 1 | A frame is in progress |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| txi_req | output | 1 | Transmit interrupt request |

## Verification
Some rules are checked by the assertions on every cycle. The readback holds still between strobes during a frame. Writes in synchronous mode, and non-zero writes while the clock line is high, leave the idle readback unchanged. Every end-of-frame pulse lasts one cycle and finds the field at zero with the frame closed. The interrupt request never fires without the empty flag. Other rules need the directed scenarios, because they depend on the full count history. These are the exact frame length for each field value in each mode, the re-encoded value after every strobe, the mode being held once a frame has started, and the effect of the enable bit.

// File: rtl/sbt_pkg.sv
// Shared types for the serial bit tally block.
package sbt_pkg;
    typedef enum logic {
        MODE_SYNC = 1'b0,
        MODE_I2C  = 1'b1
    } sbt_mode_e;
endpackage

// File: rtl/sbt_len_decode.sv
// Maps a length field and a mode to the number of bit slots in a frame.
// Assumes: zero means a full frame; I2C mode adds one acknowledge slot.
module sbt_len_decode #(
    parameter int FIELD_W = 3,
    localparam int CNT_W  = FIELD_W + 1
) (
    input  logic [FIELD_W-1:0] field,
    input  sbt_pkg::sbt_mode_e mode,
    output logic [CNT_W-1:0]   frame_len
);
    localparam logic [CNT_W-1:0] FULL_SYNC = CNT_W'(2 ** FIELD_W);
    localparam logic [CNT_W-1:0] FULL_I2C  = FULL_SYNC + CNT_W'(1);

    logic is_i2c;
    assign is_i2c = (mode == sbt_pkg::MODE_I2C);

    // Decode the wrap-around field into a slot count.
    always_comb begin
        if (field == '0) begin
            frame_len = is_i2c ? FULL_I2C : FULL_SYNC;
        end else begin
            frame_len = {1'b0, field} + (is_i2c ? CNT_W'(1) : CNT_W'(0));
        end
    end
endmodule

// File: rtl/sbt_down_counter.sv
// Slot down-counter: loaded at frame start, decremented per bit strobe.
// Assumes: load_val is never zero; busy is derived from a non-zero count.
module sbt_down_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             busy,
    output logic             last_slot,
    output logic             done
);
    assign busy      = (count != '0);
    assign last_slot = dec && (count == CNT_W'(1));

    // Load on idle start, count down while active, pulse done at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            done  <= 1'b0;
        end else begin
            done <= last_slot;
            if (load && !busy) begin
                count <= load_val;
            end else if (dec && busy) begin
                count <= count - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/sbt_field_reg.sv
// Software length field with mode-dependent write qualification.
// Assumes: clear comes from the strobe that ends a frame.
module sbt_field_reg #(
    parameter int FIELD_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [FIELD_W-1:0] wr_data,
    input  sbt_pkg::sbt_mode_e mode,
    input  logic               scl_low,
    input  logic               busy,
    input  logic               start,
    input  logic               clear,
    output logic [FIELD_W-1:0] field
);
    logic accept;

    // Accept only I2C-mode writes between frames; non-zero needs SCL low.
    always_comb begin
        accept = wr_en && !busy && !start && (mode == sbt_pkg::MODE_I2C)
                 && ((wr_data == '0) || scl_low);
    end

    // Hold the field, clear it at frame end, load it on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field <= '0;
        end else if (clear) begin
            field <= '0;
        end else if (accept) begin
            field <= wr_data;
        end
    end
endmodule

// File: rtl/sbt_irq_gate.sv
// Transmit interrupt enable bit and the request gate.
// Assumes: tx_empty is supplied by the transmit data path.
module sbt_irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic en_we,
    input  logic en_wd,
    input  logic tx_empty,
    output logic txi_req
);
    logic irq_en;

    // Store the software enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= 1'b0;
        end else if (en_we) begin
            irq_en <= en_wd;
        end
    end

    assign txi_req = tx_empty && irq_en;
endmodule

// File: rtl/serial_bit_tally.sv
// Top of the serial bit tally: length field, slot counter, readback and
// transmit interrupt gate. Assumes the strobe inputs are one-cycle pulses
// that are synchronous to clk.
module serial_bit_tally #(
    parameter int FIELD_W = 3,
    localparam int CNT_W  = FIELD_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_i2c,
    input  logic               scl_low,
    input  logic               cnt_wr_en,
    input  logic [FIELD_W-1:0] cnt_wr_data,
    input  logic               frame_start,
    input  logic               bit_strobe,
    input  logic               tx_empty,
    input  logic               irq_en_we,
    input  logic               irq_en_wd,
    output logic [FIELD_W-1:0] cnt_rd,
    output logic               frame_busy,
    output logic               frame_done,
    output logic               txi_req
);
    import sbt_pkg::*;

    sbt_mode_e          mode_live;
    sbt_mode_e          mode_q;
    logic [FIELD_W-1:0] field;
    logic [CNT_W-1:0]   frame_len;
    logic [CNT_W-1:0]   count;
    logic               busy;
    logic               last_slot;
    logic [CNT_W-1:0]   rd_wide;

    assign mode_live = mode_i2c ? MODE_I2C : MODE_SYNC;

    sbt_len_decode #(.FIELD_W(FIELD_W)) u_dec (
        .field     (field),
        .mode      (mode_live),
        .frame_len (frame_len)
    );

    sbt_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (frame_start),
        .load_val  (frame_len),
        .dec       (bit_strobe),
        .count     (count),
        .busy      (busy),
        .last_slot (last_slot),
        .done      (frame_done)
    );

    sbt_field_reg #(.FIELD_W(FIELD_W)) u_fld (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cnt_wr_en),
        .wr_data (cnt_wr_data),
        .mode    (mode_live),
        .scl_low (scl_low),
        .busy    (busy),
        .start   (frame_start),
        .clear   (last_slot),
        .field   (field)
    );

    sbt_irq_gate u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_we    (irq_en_we),
        .en_wd    (irq_en_wd),
        .tx_empty (tx_empty),
        .txi_req  (txi_req)
    );

    // Capture the mode for the whole frame when an idle start arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_SYNC;
        end else if (frame_start && !busy) begin
            mode_q <= mode_live;
        end
    end

    // Readback: the stored field when idle, the re-encoded count when active.
    always_comb begin
        rd_wide = (mode_q == MODE_I2C) ? (count - CNT_W'(1)) : count;
        cnt_rd  = busy ? rd_wide[FIELD_W-1:0] : field;
    end

    assign frame_busy = busy;
endmodule

// File: rtl/serial_bit_tally_chk.sv
// Cycle-level property checker for serial_bit_tally, bound to the top.
module serial_bit_tally_chk #(
    parameter int FIELD_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mode_i2c,
    input logic               scl_low,
    input logic               cnt_wr_en,
    input logic [FIELD_W-1:0] cnt_wr_data,
    input logic               frame_start,
    input logic               bit_strobe,
    input logic               tx_empty,
    input logic [FIELD_W-1:0] cnt_rd,
    input logic               frame_busy,
    input logic               frame_done,
    input logic               txi_req
);
    AST_RD_HOLDS_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_busy && !bit_strobe) |=> $stable(cnt_rd)); // R3
    AST_DONE_CLEAN_END: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (!frame_busy && cnt_rd == '0)); // R4
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R4
    AST_NZ_WR_NEEDS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i2c && !frame_busy && !frame_start && cnt_wr_en
         && cnt_wr_data != '0 && !scl_low) |=> $stable(cnt_rd)); // R5
    AST_SYNC_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i2c && !frame_busy && !frame_start && cnt_wr_en) |=> $stable(cnt_rd)); // R6
    AST_IDLE_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_busy && !frame_start && !cnt_wr_en && bit_strobe)
        |=> ($stable(cnt_rd) && !frame_busy && !frame_done)); // R7
    AST_IRQ_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        txi_req |-> tx_empty); // R8
endmodule

bind serial_bit_tally serial_bit_tally_chk #(.FIELD_W(FIELD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i2c    (mode_i2c),
    .scl_low     (scl_low),
    .cnt_wr_en   (cnt_wr_en),
    .cnt_wr_data (cnt_wr_data),
    .frame_start (frame_start),
    .bit_strobe  (bit_strobe),
    .tx_empty    (tx_empty),
    .cnt_rd      (cnt_rd),
    .frame_busy  (frame_busy),
    .frame_done  (frame_done),
    .txi_req     (txi_req)
);

// File: tb/sim_serial_bit_tally.sv
// Directed bench for serial_bit_tally: one task per scenario.
module sim_serial_bit_tally;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_i2c = 1'b0;
    logic       scl_low = 1'b0;
    logic       cnt_wr_en = 1'b0;
    logic [2:0] cnt_wr_data = 3'd0;
    logic       frame_start = 1'b0;
    logic       bit_strobe = 1'b0;
    logic       tx_empty = 1'b0;
    logic       irq_en_we = 1'b0;
    logic       irq_en_wd = 1'b0;
    logic [2:0] cnt_rd;
    logic       frame_busy;
    logic       frame_done;
    logic       txi_req;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    serial_bit_tally u0 (
        .clk (clk), .rst_n (rst_n), .mode_i2c (mode_i2c), .scl_low (scl_low),
        .cnt_wr_en (cnt_wr_en), .cnt_wr_data (cnt_wr_data),
        .frame_start (frame_start), .bit_strobe (bit_strobe),
        .tx_empty (tx_empty), .irq_en_we (irq_en_we), .irq_en_wd (irq_en_wd),
        .cnt_rd (cnt_rd), .frame_busy (frame_busy), .frame_done (frame_done),
        .txi_req (txi_req)
    );

    // Advance one clock; inputs change and outputs are sampled 1 ns after the edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected readback for n remaining slots (R3).
    function automatic int enc(input bit i2c, input int n);
        return i2c ? ((n - 1) & 7) : (n & 7);
    endfunction

    task automatic wr_field(input logic [2:0] v, input logic scl);
        cnt_wr_en = 1'b1; cnt_wr_data = v; scl_low = scl;
        step();
        cnt_wr_en = 1'b0; scl_low = 1'b0;
    endtask

    // Start a frame and count it down, checking every strobe.
    task automatic run_frame(input bit i2c, input int len, input string req);
        mode_i2c = i2c; frame_start = 1'b1;
        step();
        frame_start = 1'b0;
        chk({req, " busy after start"}, int'(frame_busy), 1);
        chk({"R3 readback at start ", req}, int'(cnt_rd), enc(i2c, len));
        for (int k = 1; k <= len; k++) begin
            bit_strobe = 1'b1;
            step();
            if (k < len) begin
                chk({req, " no early done"}, int'(frame_done), 0);
                chk({"R3 readback ", req}, int'(cnt_rd), enc(i2c, len - k));
            end else begin
                chk({"R4 done on last ", req}, int'(frame_done), 1);
                chk("R4 busy drops", int'(frame_busy), 0);
                chk("R4 field back to 000", int'(cnt_rd), 0);
            end
        end
        bit_strobe = 1'b0;
        step();
        chk("R4 done is one cycle", int'(frame_done), 0);
    endtask

    task automatic t_reset();
        chk("R9 reset readback", int'(cnt_rd), 0);
        chk("R9 reset busy", int'(frame_busy), 0);
        chk("R9 reset done", int'(frame_done), 0);
        tx_empty = 1'b1; #1;
        chk("R9 reset enable off", int'(txi_req), 0);
        tx_empty = 1'b0;
    endtask

    task automatic t_i2c_lengths();
        run_frame(1'b1, 9, "R1 field 000");
        wr_field(3'd1, 1'b1);
        chk("R5 write accepted scl low", int'(cnt_rd), 1);
        run_frame(1'b1, 2, "R1 field 001");
        wr_field(3'd5, 1'b1);
        run_frame(1'b1, 6, "R1 field 101");
        wr_field(3'd7, 1'b1);
        run_frame(1'b1, 8, "R1 field 111");
    endtask

    task automatic t_sync_lengths();
        mode_i2c = 1'b0;
        wr_field(3'd3, 1'b1);
        chk("R6 sync write ignored", int'(cnt_rd), 0);
        run_frame(1'b0, 8, "R2 field 000");
        mode_i2c = 1'b1;
        wr_field(3'd5, 1'b1);
        run_frame(1'b0, 5, "R2 field 101");
        mode_i2c = 1'b1;
        wr_field(3'd1, 1'b1);
        run_frame(1'b0, 1, "R2 field 001");
    endtask

    task automatic t_write_rules();
        mode_i2c = 1'b1;
        wr_field(3'd4, 1'b0);
        chk("R5 non-zero write with scl high ignored", int'(cnt_rd), 0);
        wr_field(3'd6, 1'b1);
        chk("R5 write accepted", int'(cnt_rd), 6);
        wr_field(3'd0, 1'b0);
        chk("R5 zero write with scl high accepted", int'(cnt_rd), 0);
        // A write during an active frame must not change the count or the length.
        frame_start = 1'b1;
        step();
        frame_start = 1'b0;
        wr_field(3'd2, 1'b1);
        chk("R5 write during frame ignored", int'(cnt_rd), enc(1'b1, 9));
        for (int k = 1; k <= 9; k++) begin
            bit_strobe = 1'b1;
            step();
        end
        bit_strobe = 1'b0;
        chk("R5 frame length unchanged by write", int'(frame_done), 1);
        chk("R5 field still 000 after frame", int'(cnt_rd), 0);
        step();
        // A write in the same cycle as the start must not be taken.
        cnt_wr_en = 1'b1; cnt_wr_data = 3'd3; scl_low = 1'b1; frame_start = 1'b1;
        step();
        cnt_wr_en = 1'b0; scl_low = 1'b0; frame_start = 1'b0;
        chk("R5 write with start ignored", int'(cnt_rd), enc(1'b1, 9));
        for (int k = 1; k <= 9; k++) begin
            bit_strobe = 1'b1;
            step();
        end
        bit_strobe = 1'b0;
        step();
    endtask

    task automatic t_ignored_events();
        mode_i2c = 1'b1;
        wr_field(3'd3, 1'b1);
        bit_strobe = 1'b1;
        step(); step();
        bit_strobe = 1'b0;
        chk("R7 idle strobe keeps field", int'(cnt_rd), 3);
        chk("R7 idle strobe no frame", int'(frame_busy), 0);
        // Field 011 in I2C gives 4 slots; a mode change or a restart mid-frame has no effect.
        frame_start = 1'b1;
        step();
        frame_start = 1'b0;
        bit_strobe = 1'b1;
        step();
        bit_strobe = 1'b0; mode_i2c = 1'b0; frame_start = 1'b1;
        step();
        frame_start = 1'b0;
        chk("R7 mode held and restart ignored", int'(cnt_rd), enc(1'b1, 3));
        for (int k = 1; k <= 3; k++) begin
            bit_strobe = 1'b1;
            step();
        end
        bit_strobe = 1'b0;
        chk("R7 frame length kept", int'(frame_done), 1);
        step();
    endtask

    task automatic t_irq();
        tx_empty = 1'b1;
        irq_en_we = 1'b1; irq_en_wd = 1'b1;
        step();
        irq_en_we = 1'b0;
        chk("R8 enabled and empty", int'(txi_req), 1);
        tx_empty = 1'b0; #1;
        chk("R8 not empty", int'(txi_req), 0);
        tx_empty = 1'b1;
        irq_en_we = 1'b1; irq_en_wd = 1'b0;
        step();
        irq_en_we = 1'b0;
        chk("R8 masked", int'(txi_req), 0);
        tx_empty = 1'b0;
    endtask

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_i2c_lengths();
        t_sync_lengths();
        t_write_rules();
        t_ignored_events();
        t_irq();
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule